// File: doc/BRIEF.md
# Linked-Descriptor Packet DMA Channel

This block is one direction of a packet DMA engine. Software builds a chain of four-word descriptors in the channel's own descriptor RAM. Each descriptor points at a byte buffer in the same RAM. The host starts the channel by writing the byte address of the first descriptor to the head-pointer input. The channel then fetches each descriptor in turn. It streams the buffer's bytes out of a valid/ready byte port and writes the mode word back so that ownership returns to software. It follows the next pointer until that pointer is zero.

Progress is reported through a completion pointer. After every finished descriptor the channel loads that descriptor's address into the pointer and raises an event. The host clears the event by writing the same value back. When a descriptor is retired with a zero next pointer it is tagged end-of-queue. Software that has appended work after the channel drained can see this tag and restart the channel with a fresh head-pointer write. A teardown request stops the channel at the next descriptor boundary. It tags the descriptor it was working on and places a fixed marker in the completion pointer.

Top module: `ldma_channel`

## Requirements
- R1: A descriptor occupies four consecutive 32-bit RAM words at a byte address that is a multiple of 4. Word 0 holds the next-descriptor byte address. Word 1 holds the buffer byte address. Word 2 holds the buffer length in bytes in bits 10:0. Word 3 is the mode word. The channel follows next pointers and stops after a descriptor whose next pointer is zero.
- R2: When the channel is idle, a head-pointer write with a nonzero value starts processing at that descriptor address. A head-pointer write of zero leaves the channel idle.
- R3: Buffer bytes leave the stream port in ascending address order, one byte per beat on which both valid and ready are high. A byte at address A sits in bits 8*(A mod 4)+7 down to 8*(A mod 4) of RAM word A/4. While ready is low, valid and the data byte hold their values.
- R4: Last is raised with the final byte of a descriptor only when its mode bit 30 (end of packet) is set. After that final beat, valid drops.
- R5: When a descriptor is finished, its mode word is written back with bit 29 (hardware ownership) cleared and bits 10:0 set to the number of bytes moved. All other bits are kept, including bit 31 (start of packet), bit 30 and bit 26 (CRC included). When bit 26 is set, the moved count includes the buffer's trailing 4 CRC bytes.
- R6: A finished descriptor whose next pointer is zero is written back with bit 28 (end of queue) set, and the channel goes idle. A descriptor with a nonzero next pointer keeps bit 28 clear.
- R7: After each finished descriptor the completion pointer holds that descriptor's byte address, and the completion event is high. The completion pointer changes only when the event is also high.
- R8: The completion event stays high until the host writes the completion-acknowledge input with a value equal to the completion pointer. An acknowledge with any other value is ignored.
- R9: A head-pointer write while the channel is busy is ignored. The descriptor it names is left unmodified and streams nothing.
- R10: A fetched descriptor with mode bit 29 clear stops the channel. That descriptor is not modified, no byte is streamed, and the completion pointer and event are left unchanged.
- R11: A teardown request while busy lets the current descriptor finish. That descriptor is written back with bit 27 (teardown complete) set. The completion pointer then becomes 0xFFFFFFFC with the event high, the channel goes idle, and later descriptors in the chain are left untouched.
- R12: A teardown request while idle loads 0xFFFFFFFC into the completion pointer and raises the event within two clock cycles.
- R13: A descriptor with length zero streams no beats. It is still written back as finished and reported through the completion pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memWe | input | 1 | Host write strobe into the descriptor RAM |
| memRe | input | 1 | Host read strobe; data appears on memRdata one cycle later |
| memAddr | input | AW | Host RAM word index |
| memWdata | input | 32 | Host RAM write data |
| memRdata | output | 32 | Host RAM read data (registered) |
| headWe | input | 1 | Head-pointer write strobe |
| headData | input | 32 | Head descriptor byte address |
| cplWe | input | 1 | Completion-acknowledge write strobe |
| cplData | input | 32 | Completion-acknowledge value |
| teardownReq | input | 1 | One-cycle teardown request |
| cplPtr | output | 32 | Completion pointer |
| cplEvent | output | 1 | Completion not yet acknowledged |
| busy | output | 1 | Channel is working through a chain |
| outData | output | 8 | Stream byte |
| outValid | output | 1 | Stream byte valid |
| outReady | input | 1 | Stream sink ready |
| outLast | output | 1 | Final byte of a packet |

## Verification
Some rules are checked on every cycle. Stream data and last hold while the sink stalls. Valid drops after an end-of-packet beat. The completion pointer only moves while the event is raised. The event falls only on a matching acknowledge, and a mismatching acknowledge never clears it. Other behaviour can only be shown by the bench's scenarios, because it needs the contents of the descriptor RAM to be predicted and read back. This covers byte order across unaligned buffers, the written-back mode bits (ownership, end of queue, teardown complete and the length field), and the ignored head write while busy. It also covers the untouched unowned descriptor, the descriptor skipped by teardown, and the end-of-queue restart.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  // Mode word bit positions
  localparam int SOP_B = 31;
  localparam int EOP_B = 30;
  localparam int OWN_B = 29;
  localparam int EOQ_B = 28;
  localparam int TDC_B = 27;
  localparam int CRC_B = 26;

  // Width of the length field in the length and mode words
  localparam int LEN_W = 11;

  // Value placed in the completion pointer when a teardown finishes
  localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD0,
    S_RD1,
    S_RD2,
    S_RD3,
    S_CAPM,
    S_DECIDE,
    S_FETCH,
    S_SEND,
    S_WB
  } chanState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadHead;
    logic       rdEn;
    logic [1:0] descWord;
    logic       selBuf;
    logic       capNext;
    logic       capBuf;
    logic       capLen;
    logic       capMode;
    logic       byteAdv;
    logic       writeBack;
    logic       followNext;
    logic       markCpl;
  } ctrlStrb_t;

  // Status from datapath to control
  typedef struct packed {
    logic headOk;
    logic owned;
    logic lenZero;
    logic lastByte;
    logic wordEnd;
    logic nextZero;
    logic tdPend;
  } dpStat_t;

endpackage

// File: rtl/ldma_ram.sv
module ldma_ram #(
  parameter int WORDS = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          hostWe,
  input  logic          hostRe,
  input  logic [AW-1:0] hostAddr,
  input  logic [31:0]   hostWdata,
  output logic [31:0]   hostRdata,
  input  logic          engWe,
  input  logic          engRe,
  input  logic [AW-1:0] engAddr,
  input  logic [31:0]   engWdata,
  output logic [31:0]   engRdata
);

  logic [31:0] mem [WORDS];

  // The engine write comes second, so it wins when both ports hit the same word.
  always_ff @(posedge clk) begin
    if (hostWe) mem[hostAddr] <= hostWdata;
    if (engWe)  mem[engAddr]  <= engWdata;
    if (hostRe) hostRdata <= mem[hostAddr];
    if (engRe)  engRdata  <= mem[engAddr];
  end

endmodule

// File: rtl/ldma_datapath.sv
module ldma_datapath
  import ldma_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  output dpStat_t       stat,
  input  logic          headWe,
  input  logic [31:0]   headData,
  input  logic          cplWe,
  input  logic [31:0]   cplData,
  input  logic          teardownReq,
  output logic          engWe,
  output logic          engRe,
  output logic [AW-1:0] engAddr,
  output logic [31:0]   engWdata,
  input  logic [31:0]   engRdata,
  output logic [31:0]   cplPtr,
  output logic          cplEvent,
  output logic [7:0]    byteData,
  output logic          byteLast
);

  localparam int BW = AW + 2;  // byte address width inside the RAM

  logic [31:0]      descPtr;
  logic [31:0]      nextPtr;
  logic [BW-1:0]    bufPtr;
  logic [LEN_W-1:0] lenReg;
  logic [31:0]      modeReg;
  logic [LEN_W-1:0] byteCnt;
  logic [31:0]      cplReg;
  logic             pendReg;
  logic             tdPend;

  logic [BW-1:0]    curByte;
  logic [31:0]      wbWord;
  logic [AW-1:0]    descBase;

  assign descBase = descPtr[AW+1:2];
  assign curByte  = bufPtr + BW'(byteCnt);

  // Descriptor fields and buffer progress
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= '0;
      nextPtr <= '0;
      bufPtr  <= '0;
      lenReg  <= '0;
      modeReg <= '0;
      byteCnt <= '0;
    end else begin
      if (strb.loadHead)   descPtr <= headData;
      if (strb.followNext) descPtr <= nextPtr;
      if (strb.capNext)    nextPtr <= engRdata;
      if (strb.capBuf)     bufPtr  <= engRdata[BW-1:0];
      if (strb.capLen) begin
        lenReg  <= engRdata[LEN_W-1:0];
        byteCnt <= '0;
      end
      if (strb.capMode)    modeReg <= engRdata;
      if (strb.byteAdv)    byteCnt <= byteCnt + LEN_W'(1);
    end
  end

  // Completion pointer, event and teardown request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cplReg  <= '0;
      pendReg <= 1'b0;
      tdPend  <= 1'b0;
    end else begin
      if (strb.writeBack) begin
        cplReg  <= tdPend ? TD_MARK : descPtr;
        pendReg <= 1'b1;
      end else if (strb.markCpl) begin
        cplReg  <= TD_MARK;
        pendReg <= 1'b1;
      end else if (cplWe && (cplData == cplReg)) begin
        pendReg <= 1'b0;
      end
      if (strb.writeBack || strb.markCpl) tdPend <= 1'b0;
      if (teardownReq)                    tdPend <= 1'b1;
    end
  end

  // Mode word returned to software
  always_comb begin
    wbWord                = modeReg;
    wbWord[OWN_B]         = 1'b0;
    wbWord[EOQ_B]         = (nextPtr == '0);
    wbWord[TDC_B]         = tdPend;
    wbWord[LEN_W-1:0]     = lenReg;
  end

  // Engine RAM port
  always_comb begin
    if (strb.writeBack)   engAddr = descBase + AW'(3);
    else if (strb.selBuf) engAddr = curByte[BW-1:2];
    else                  engAddr = descBase + AW'(strb.descWord);
  end

  assign engWe    = strb.writeBack;
  assign engRe    = strb.rdEn;
  assign engWdata = wbWord;

  assign byteData = engRdata[{curByte[1:0], 3'b000} +: 8];
  assign byteLast = modeReg[EOP_B] && stat.lastByte;

  assign cplPtr   = cplReg;
  assign cplEvent = pendReg;

  always_comb begin
    stat.headOk   = headWe && (headData != '0);
    stat.owned    = modeReg[OWN_B];
    stat.lenZero  = (lenReg == '0);
    stat.lastByte = (byteCnt == lenReg - LEN_W'(1));
    stat.wordEnd  = (curByte[1:0] == 2'b11);
    stat.nextZero = (nextPtr == '0);
    stat.tdPend   = tdPend;
  end

endmodule

// File: rtl/ldma_ctrl.sv
module ldma_ctrl
  import ldma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStat_t   stat,
  input  logic      outReady,
  output ctrlStrb_t strb,
  output logic      outValid,
  output logic      busy
);

  chanState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    outValid  = 1'b0;
    case (state)
      S_IDLE: begin
        if (stat.tdPend) begin
          strb.markCpl = 1'b1;
        end else if (stat.headOk) begin
          strb.loadHead = 1'b1;
          nextState     = S_RD0;
        end
      end
      S_RD0: begin
        strb.rdEn     = 1'b1;
        strb.descWord = 2'd0;
        nextState     = S_RD1;
      end
      S_RD1: begin
        strb.rdEn     = 1'b1;
        strb.descWord = 2'd1;
        strb.capNext  = 1'b1;
        nextState     = S_RD2;
      end
      S_RD2: begin
        strb.rdEn     = 1'b1;
        strb.descWord = 2'd2;
        strb.capBuf   = 1'b1;
        nextState     = S_RD3;
      end
      S_RD3: begin
        strb.rdEn     = 1'b1;
        strb.descWord = 2'd3;
        strb.capLen   = 1'b1;
        nextState     = S_CAPM;
      end
      S_CAPM: begin
        strb.capMode = 1'b1;
        nextState    = S_DECIDE;
      end
      S_DECIDE: begin
        if (!stat.owned)       nextState = S_IDLE;
        else if (stat.lenZero) nextState = S_WB;
        else                   nextState = S_FETCH;
      end
      S_FETCH: begin
        strb.rdEn   = 1'b1;
        strb.selBuf = 1'b1;
        nextState   = S_SEND;
      end
      S_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          strb.byteAdv = 1'b1;
          if (stat.lastByte)     nextState = S_WB;
          else if (stat.wordEnd) nextState = S_FETCH;
        end
      end
      S_WB: begin
        strb.writeBack = 1'b1;
        if (stat.tdPend || stat.nextZero) begin
          nextState = S_IDLE;
        end else begin
          strb.followNext = 1'b1;
          nextState       = S_RD0;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
  import ldma_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int AW        = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          memWe,
  input  logic          memRe,
  input  logic [AW-1:0] memAddr,
  input  logic [31:0]   memWdata,
  output logic [31:0]   memRdata,
  input  logic          headWe,
  input  logic [31:0]   headData,
  input  logic          cplWe,
  input  logic [31:0]   cplData,
  input  logic          teardownReq,
  output logic [31:0]   cplPtr,
  output logic          cplEvent,
  output logic          busy,
  output logic [7:0]    outData,
  output logic          outValid,
  input  logic          outReady,
  output logic          outLast
);

  ctrlStrb_t     strb;
  dpStat_t       stat;
  logic          engWe;
  logic          engRe;
  logic [AW-1:0] engAddr;
  logic [31:0]   engWdata;
  logic [31:0]   engRdata;
  logic          byteLast;

  ldma_ram #(.WORDS(MEM_WORDS), .AW(AW)) i_ram (
    .clk       (clk),
    .hostWe    (memWe),
    .hostRe    (memRe),
    .hostAddr  (memAddr),
    .hostWdata (memWdata),
    .hostRdata (memRdata),
    .engWe     (engWe),
    .engRe     (engRe),
    .engAddr   (engAddr),
    .engWdata  (engWdata),
    .engRdata  (engRdata)
  );

  ldma_datapath #(.AW(AW)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .headWe      (headWe),
    .headData    (headData),
    .cplWe       (cplWe),
    .cplData     (cplData),
    .teardownReq (teardownReq),
    .engWe       (engWe),
    .engRe       (engRe),
    .engAddr     (engAddr),
    .engWdata    (engWdata),
    .engRdata    (engRdata),
    .cplPtr      (cplPtr),
    .cplEvent    (cplEvent),
    .byteData    (outData),
    .byteLast    (byteLast)
  );

  ldma_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .outReady (outReady),
    .strb     (strb),
    .outValid (outValid),
    .busy     (busy)
  );

  assign outLast = outValid && byteLast;

endmodule

// File: rtl/ldma_channel_chk.sv
module ldma_channel_chk (
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outData,
  input logic        outLast,
  input logic        busy,
  input logic        cplEvent,
  input logic [31:0] cplPtr,
  input logic        cplWe,
  input logic [31:0] cplData
);

  // R3: a stalled beat keeps its byte and last flag
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R3: no beat is offered while the channel is idle
  a_r3_valid_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R4: the end-of-packet beat is followed by a gap
  a_r4_last_ends_packet: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);

  // R7: the completion pointer moves only together with a raised event
  a_r7_ptr_moves_with_event: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cplPtr) |-> cplEvent);

  // R8: a mismatching acknowledge leaves the event raised
  a_r8_wrong_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cplEvent && cplWe && (cplData != cplPtr)) |=> cplEvent);

  // R8: the event only falls after a matching acknowledge
  a_r8_fall_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cplEvent) |-> ($past(cplWe) && ($past(cplData) == $past(cplPtr))));

endmodule

bind ldma_channel ldma_channel_chk i_chk (.*);

// File: tb/test_ldma_channel.sv
`timescale 1ns/1ps
module test_ldma_channel;

  localparam int MEM_WORDS = 256;
  localparam int AW = $clog2(MEM_WORDS);

  localparam logic [31:0] M_SOP = 32'h8000_0000;
  localparam logic [31:0] M_EOP = 32'h4000_0000;
  localparam logic [31:0] M_OWN = 32'h2000_0000;
  localparam logic [31:0] M_EOQ = 32'h1000_0000;
  localparam logic [31:0] M_TDC = 32'h0800_0000;
  localparam logic [31:0] M_CRC = 32'h0400_0000;
  localparam logic [31:0] MARK  = 32'hFFFF_FFFC;

  // [31:24] buffer offset from 0x100, [23:16] ready pattern,
  // [14] end of packet, [13] CRC included, [10:0] length
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00FF_4008,
    32'h015A_4007,
    32'h0333_0005,
    32'h02FF_600A,
    32'h0081_4001,
    32'h056F_400D
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          memWe = 1'b0;
  logic          memRe = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic [31:0]   memWdata = '0;
  logic [31:0]   memRdata;
  logic          headWe = 1'b0;
  logic [31:0]   headData = '0;
  logic          cplWe = 1'b0;
  logic [31:0]   cplData = '0;
  logic          teardownReq = 1'b0;
  logic [31:0]   cplPtr;
  logic          cplEvent;
  logic          busy;
  logic [7:0]    outData;
  logic          outValid;
  logic          outReady = 1'b0;
  logic          outLast;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ldma_channel #(.MEM_WORDS(MEM_WORDS)) i_ldma_channel (
    .clk, .rstN, .memWe, .memRe, .memAddr, .memWdata, .memRdata,
    .headWe, .headData, .cplWe, .cplData, .teardownReq,
    .cplPtr, .cplEvent, .busy, .outData, .outValid, .outReady, .outLast
  );

  function automatic logic [7:0] bval(input int a);
    return 8'((a * 13 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrWord(input int byteAddr, input logic [31:0] d);
    @(negedge clk);
    memWe = 1'b1; memAddr = AW'(byteAddr >> 2); memWdata = d;
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic rdWord(input int byteAddr, output logic [31:0] d);
    @(negedge clk);
    memRe = 1'b1; memAddr = AW'(byteAddr >> 2);
    @(negedge clk);
    memRe = 1'b0;
    d = memRdata;
  endtask

  task automatic wrDesc(input int a, input logic [31:0] nxt, input logic [31:0] buff,
                        input logic [31:0] len, input logic [31:0] mode);
    wrWord(a, nxt); wrWord(a + 4, buff); wrWord(a + 8, len); wrWord(a + 12, mode);
  endtask

  task automatic startHead(input logic [31:0] a);
    @(negedge clk);
    headWe = 1'b1; headData = a;
    @(negedge clk);
    headWe = 1'b0;
  endtask

  task automatic ack(input logic [31:0] v);
    @(negedge clk);
    cplWe = 1'b1; cplData = v;
    @(negedge clk);
    cplWe = 1'b0;
  endtask

  task automatic collect(input int base, input int n, input bit eop, input logic [7:0] pat, input string tag);
    int got = 0;
    for (int k = 0; k < 4000 && got < n; k++) begin
      @(negedge clk);
      outReady = pat[k % 8];
      if (outValid && outReady) begin
        chk(outData == bval(base + got) && outLast == (eop && got == n - 1), tag,
            {23'd0, outLast, outData}, {23'd0, (eop && got == n - 1), bval(base + got)});
        got++;
      end
    end
    chk(got == n, {tag, " beat count"}, 32'(got), 32'(n));
  endtask

  task automatic waitIdle(input string tag);
    int k = 0;
    @(negedge clk);
    while (busy && k < 500) begin
      @(negedge clk);
      k++;
    end
    chk(!busy, {tag, " channel idle"}, {31'd0, busy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] mode;
    int seen;

    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !outValid && !cplEvent && cplPtr == 0, "reset state",
        {cplPtr[27:0], busy, outValid, cplEvent, 1'b0}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // fill buffer area, words 64..255
    for (int w = 64; w < MEM_WORDS; w++)
      wrWord(w * 4, {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)});

    // vector table: single-descriptor packets
    for (int i = 0; i < NVEC; i++) begin
      int da;
      int ba;
      int ln;
      da = 16 * (i + 1);
      ba = 32'h100 + int'(VEC[i][31:24]);
      ln = int'(VEC[i][10:0]);
      mode = M_OWN | M_SOP | (VEC[i][14] ? M_EOP : 0) | (VEC[i][13] ? M_CRC : 0);
      wrDesc(da, 0, ba, ln, mode);
      startHead(da);
      collect(ba, ln, VEC[i][14], VEC[i][23:16], "R3 R4 vector byte");
      waitIdle("R6 vector");
      rdWord(da + 12, d);
      chk(d == ((mode & ~M_OWN) | M_EOQ | ln), "R5 R6 vector write-back", d, (mode & ~M_OWN) | M_EOQ | ln);
      chk(cplPtr == da && cplEvent, "R7 vector completion", cplPtr, da);
      ack(32'hDEAD_0000);
      chk(cplEvent, "R8 mismatched ack ignored", {31'd0, cplEvent}, 1);
      ack(da);
      chk(!cplEvent, "R8 matching ack clears", {31'd0, cplEvent}, 0);
    end

    // zero head pointer write is ignored (R2)
    startHead(0);
    @(negedge clk);
    chk(!busy, "R2 zero head ignored", {31'd0, busy}, 0);

    // chain of three plus an ignored head write while busy (R1, R9)
    wrDesc(32'h40, 32'h50, 32'h120, 6, M_OWN | M_SOP);
    wrDesc(32'h50, 32'h60, 32'h130, 3, M_OWN);
    wrDesc(32'h60, 0, 32'h141, 4, M_OWN | M_EOP);
    wrDesc(32'h90, 0, 32'h150, 2, M_OWN | M_SOP | M_EOP);
    outReady = 1'b0;
    startHead(32'h40);
    repeat (10) @(negedge clk);
    startHead(32'h90);
    collect(32'h120, 6, 0, 8'hFF, "R1 chain first");
    collect(32'h130, 3, 0, 8'hFF, "R1 chain second");
    collect(32'h141, 4, 1, 8'hFF, "R1 chain third");
    waitIdle("R1 chain");
    rdWord(32'h4C, d);
    chk(d == (M_SOP | 6), "R6 mid-chain no end of queue", d, M_SOP | 6);
    rdWord(32'h6C, d);
    chk(d == (M_EOP | M_EOQ | 4), "R6 chain tail end of queue", d, M_EOP | M_EOQ | 4);
    rdWord(32'h9C, d);
    chk(d == (M_OWN | M_SOP | M_EOP), "R9 busy head write ignored", d, M_OWN | M_SOP | M_EOP);
    chk(cplPtr == 32'h60, "R7 chain completion pointer", cplPtr, 32'h60);
    ack(32'h60);

    // descriptor not owned (R10)
    mode = M_SOP | M_EOP | 32'd5;
    wrDesc(32'hA0, 0, 32'h100, 3, mode);
    outReady = 1'b1;
    startHead(32'hA0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0 && !busy, "R10 unowned streams nothing", 32'(seen), 0);
    rdWord(32'hAC, d);
    chk(d == mode, "R10 unowned left unmodified", d, mode);
    chk(cplPtr == 32'h60 && !cplEvent, "R10 completion unchanged", cplPtr, 32'h60);

    // zero length (R13)
    wrDesc(32'h70, 0, 32'h100, 0, M_OWN | M_SOP | M_EOP);
    startHead(32'h70);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0 && !busy, "R13 zero length no beats", 32'(seen), 0);
    rdWord(32'h7C, d);
    chk(d == (M_SOP | M_EOP | M_EOQ), "R13 zero length write-back", d, M_SOP | M_EOP | M_EOQ);
    chk(cplPtr == 32'h70 && cplEvent, "R13 zero length completion", cplPtr, 32'h70);
    ack(32'h70);

    // teardown while busy (R11)
    wrDesc(32'hB0, 32'hC0, 32'h160, 5, M_OWN | M_SOP | M_EOP);
    wrDesc(32'hC0, 0, 32'h170, 3, M_OWN | M_SOP | M_EOP);
    outReady = 1'b0;
    startHead(32'hB0);
    repeat (8) @(negedge clk);
    teardownReq = 1'b1;
    @(negedge clk);
    teardownReq = 1'b0;
    collect(32'h160, 5, 1, 8'hFF, "R11 teardown current packet");
    waitIdle("R11 teardown");
    rdWord(32'hBC, d);
    chk(d == (M_SOP | M_EOP | M_TDC | 5), "R11 teardown complete bit", d, M_SOP | M_EOP | M_TDC | 5);
    rdWord(32'hCC, d);
    chk(d == (M_OWN | M_SOP | M_EOP), "R11 later descriptor untouched", d, M_OWN | M_SOP | M_EOP);
    chk(cplPtr == MARK && cplEvent, "R11 teardown marker", cplPtr, MARK);
    ack(MARK);
    chk(!cplEvent, "R8 marker ack clears", {31'd0, cplEvent}, 0);

    // teardown while idle (R12)
    wrWord(32'h1C, 0);
    startHead(32'h0);
    @(negedge clk);
    teardownReq = 1'b1;
    @(negedge clk);
    teardownReq = 1'b0;
    @(negedge clk);
    chk(cplPtr == MARK && cplEvent && !busy, "R12 idle teardown marker", cplPtr, MARK);
    ack(MARK);

    // end-of-queue restart (R2, R6)
    wrDesc(32'hD0, 0, 32'h180, 2, M_OWN | M_SOP | M_EOP);
    startHead(32'hD0);
    collect(32'h180, 2, 1, 8'hFF, "R2 restart first");
    waitIdle("R2 restart first");
    ack(32'hD0);
    wrDesc(32'hE0, 0, 32'h190, 3, M_OWN | M_SOP | M_EOP);
    wrWord(32'hD0, 32'hE0);
    rdWord(32'hDC, d);
    chk((d & M_EOQ) != 0, "R6 drained queue flagged", d, d | M_EOQ);
    startHead(32'hE0);
    collect(32'h190, 3, 1, 8'hFF, "R2 restart second");
    waitIdle("R2 restart second");
    chk(cplPtr == 32'hE0 && cplEvent, "R2 restart completion", cplPtr, 32'hE0);
    ack(32'hE0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule